// File: doc/BRIEF.md
# Five-State Snooping Coherence Line Controller

This block holds the coherence state of every line in a small cache and decides, for each processor request and each snooped bus operation, what the cache must do on the bus. Besides Invalid, Shared, Exclusive and Modified it keeps an Owned state. A dirty line that another cache reads becomes Owned rather than being written back. The owning cache then answers all later reads of that line, and it alone writes the line back to memory when the line is evicted.

On the processor side the block accepts read, write and evict requests for one line index per cycle. It issues a bus read, read-exclusive or upgrade where one is needed, and it flags a memory write-back when a dirty line leaves the cache. On the snoop side it accepts bus read, read-exclusive and upgrade operations. It raises a data-supply flag when this cache must provide the line, and it moves the line to its new state. Data arrays, victim choice and bus ordering belong to the surrounding cache. Every operation is treated as atomic: request outputs are combinational in the same cycle, and the state changes at the next clock edge. A probe port reads back the state of any line.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on the probe port, and all request, supply and write-back outputs are low. Probe codes are Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4.
- R2: A processor read (cpu_op=0) to an Invalid line issues a bus read (bus_op=0). The line becomes Shared if cpu_peer_copy is high and Exclusive otherwise. A read to any valid line issues nothing and leaves the state unchanged.
- R3: A snooped bus read (snp_op=0) to a Modified line raises supply, leaves write-back low and moves the line to Owned.
- R4: A processor write (cpu_op=1) behaves as follows. From Invalid it issues read-exclusive (bus_op=1) with invalidate. From Shared or Owned it issues upgrade (bus_op=2) with invalidate. From Exclusive it issues nothing. Every case ends in Modified.
- R5: A snooped bus read to an Owned line raises supply and leaves the line Owned. A snooped bus read to an Exclusive line raises supply and moves the line to Shared.
- R6: An evict (cpu_op=2) of an Owned or Modified line raises write-back. An evict of a Shared or Exclusive line is silent. Every evict leaves the line Invalid.
- R7: A snooped read-exclusive (snp_op=1) to a Modified, Owned or Exclusive line raises supply. A snooped read-exclusive to a Shared line does not. In each case the line becomes Invalid.
- R8: A Shared line never raises supply, whatever the snooped operation.
- R9: A snooped upgrade (snp_op=2) leaves every line Invalid, with supply and write-back low. This includes an Owned line.
- R10: A snoop to an Invalid line raises nothing and leaves it Invalid.
- R11: When a snoop and a processor request arrive in the same cycle, the snoop is applied and cpu_stall is high. The processor request then issues nothing and changes no state.
- R12: An operation on one line index leaves the state of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 no operation |
| cpu_idx | input | IW | Line index of the processor request |
| cpu_peer_copy | input | 1 | Another cache answered the bus read with a copy |
| cpu_stall | output | 1 | Processor request not taken this cycle |
| snp_valid | input | 1 | Snooped operation present |
| snp_op | input | 2 | 0 bus read, 1 read-exclusive, 2 upgrade, 3 no operation |
| snp_idx | input | IW | Line index of the snoop |
| bus_req | output | 1 | Bus request issued for the processor request |
| bus_op | output | 2 | Bus operation, same coding as snp_op |
| inval | output | 1 | The request invalidates copies held elsewhere |
| supply | output | 1 | This cache provides the snooped line |
| wb | output | 1 | Write the line back to memory |
| probe_idx | input | IW | Line index to read back |
| probe_state | output | 3 | State of the probed line |

## Verification
The bench walks every line through each of the five states and applies every processor and snoop operation from each state. It compares the outputs and the resulting state with a table built from the requirements. The corners it targets are these. A Modified line hit by a bus read that wrote back, or fell to Shared, would lose the owner. An Owned line that was upgraded elsewhere and still wrote back would push stale data over newer data. A Shared line that supplied would collide with the owner on the bus. An Exclusive write that went to the bus would waste a transaction. A collision between a snoop and a processor request that let the processor request through would corrupt the state. The bench also checks a neighbouring line after each step, so a decode error that touches the wrong index shows up.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  localparam int STW = 3;

  typedef enum logic [STW-1:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    CPU_RD  = 2'd0,
    CPU_WR  = 2'd1,
    CPU_EV  = 2'd2,
    CPU_NOP = 2'd3
  } cpu_op_t;

  typedef enum logic [1:0] {
    BUS_RD   = 2'd0,
    BUS_RDX  = 2'd1,
    BUS_UPGR = 2'd2,
    BUS_NOP  = 2'd3
  } bus_op_t;
endpackage

// File: rtl/moesi_cpu_ctrl.sv
module moesi_cpu_ctrl
  import moesi_pkg::*;
(
  input  logic     go,
  input  cpu_op_t  op,
  input  line_st_t cur,
  input  logic     peer_copy,
  output logic     upd,
  output line_st_t nxt,
  output logic     req,
  output bus_op_t  req_op,
  output logic     inv,
  output logic     wb
);
  always_comb begin
    upd    = 1'b0;
    nxt    = cur;
    req    = 1'b0;
    req_op = BUS_RD;
    inv    = 1'b0;
    wb     = 1'b0;
    if (go) begin
      unique case (op)
        CPU_RD: begin
          if (cur == ST_I) begin
            req = 1'b1;
            upd = 1'b1;
            nxt = peer_copy ? ST_S : ST_E;
          end
        end
        CPU_WR: begin
          upd = 1'b1;
          nxt = ST_M;
          if (cur == ST_I) begin
            req    = 1'b1;
            req_op = BUS_RDX;
            inv    = 1'b1;
          end else if (cur == ST_S || cur == ST_O) begin
            req    = 1'b1;
            req_op = BUS_UPGR;
            inv    = 1'b1;
          end
        end
        CPU_EV: begin
          upd = 1'b1;
          nxt = ST_I;
          wb  = (cur == ST_M) || (cur == ST_O);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
(
  input  logic     go,
  input  bus_op_t  op,
  input  line_st_t cur,
  output logic     upd,
  output line_st_t nxt,
  output logic     supply
);
  logic dirty_or_excl;
  assign dirty_or_excl = (cur == ST_M) || (cur == ST_O) || (cur == ST_E);

  always_comb begin
    upd    = 1'b0;
    nxt    = cur;
    supply = 1'b0;
    if (go && cur != ST_I) begin
      unique case (op)
        BUS_RD: begin
          supply = dirty_or_excl;
          if (cur == ST_M) begin
            upd = 1'b1;
            nxt = ST_O;
          end else if (cur == ST_E) begin
            upd = 1'b1;
            nxt = ST_S;
          end
        end
        BUS_RDX: begin
          supply = dirty_or_excl;
          upd    = 1'b1;
          nxt    = ST_I;
        end
        BUS_UPGR: begin
          upd = 1'b1;
          nxt = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/moesi_state_store.sv
module moesi_state_store
  import moesi_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IW-1:0]      widx,
  input  line_st_t           wdata,
  output logic [LINES*STW-1:0] st_flat
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic     en;
    line_st_t q;
    assign en = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= ST_I;
      else if (en) q <= wdata;
    end
    assign st_flat[g*STW +: STW] = q;
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic [1:0]    cpu_op,
  input  logic [IW-1:0] cpu_idx,
  input  logic          cpu_peer_copy,
  output logic          cpu_stall,
  input  logic          snp_valid,
  input  logic [1:0]    snp_op,
  input  logic [IW-1:0] snp_idx,
  output logic          bus_req,
  output logic [1:0]    bus_op,
  output logic          inval,
  output logic          supply,
  output logic          wb,
  input  logic [IW-1:0] probe_idx,
  output logic [2:0]    probe_state
);
  logic [LINES*STW-1:0] st_flat;
  line_st_t cpu_st, snp_st;
  logic     cpu_go;
  logic     c_upd, s_upd, c_req, c_inv, c_wb, s_sup;
  line_st_t c_nxt, s_nxt;
  bus_op_t  c_rop;
  logic     we;
  logic [IW-1:0] widx;
  line_st_t wdata;

  assign cpu_st = line_st_t'(st_flat[cpu_idx*STW +: STW]);
  assign snp_st = line_st_t'(st_flat[snp_idx*STW +: STW]);
  assign cpu_go = cpu_valid && !snp_valid;

  moesi_cpu_ctrl u_cpu (
    .go(cpu_go), .op(cpu_op_t'(cpu_op)), .cur(cpu_st), .peer_copy(cpu_peer_copy),
    .upd(c_upd), .nxt(c_nxt), .req(c_req), .req_op(c_rop), .inv(c_inv), .wb(c_wb)
  );

  moesi_snoop_ctrl u_snp (
    .go(snp_valid), .op(bus_op_t'(snp_op)), .cur(snp_st),
    .upd(s_upd), .nxt(s_nxt), .supply(s_sup)
  );

  always_comb begin
    we    = s_upd || c_upd;
    widx  = s_upd ? snp_idx : cpu_idx;
    wdata = s_upd ? s_nxt : c_nxt;
  end

  moesi_state_store #(.LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(wdata), .st_flat(st_flat)
  );

  assign cpu_stall   = cpu_valid && snp_valid;
  assign bus_req     = c_req;
  assign bus_op      = c_req ? c_rop : 2'd0;
  assign inval       = c_inv;
  assign supply      = s_sup;
  assign wb          = c_wb;
  assign probe_state = st_flat[probe_idx*STW +: STW];
endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
  parameter int LINES = 4,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_valid,
  input logic [1:0]       cpu_op,
  input logic [IW-1:0]    cpu_idx,
  input logic             cpu_stall,
  input logic             snp_valid,
  input logic [1:0]       snp_op,
  input logic [IW-1:0]    snp_idx,
  input logic             bus_req,
  input logic [1:0]       bus_op,
  input logic             supply,
  input logic             wb,
  input logic [LINES*3-1:0] st_flat
);
  function automatic logic [2:0] pick(input logic [LINES*3-1:0] f, input logic [IW-1:0] i);
    return f[i*3 +: 3];
  endfunction

  // R3: dirty line read by a peer turns owner, no write-back
  a_r3_modified_to_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == 2'd0 && pick(st_flat, snp_idx) == 3'd4)
      |-> supply && !wb);
  a_r3_owned_next: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == 2'd0 && pick(st_flat, snp_idx) == 3'd4)
      |=> pick(st_flat, $past(snp_idx)) == 3'd3);

  // R6: owner eviction writes back
  a_r6_owner_evict_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !snp_valid && cpu_op == 2'd2 && pick(st_flat, cpu_idx) == 3'd3) |-> wb);

  // R8: shared copies stay quiet on snoops
  a_r8_shared_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && pick(st_flat, snp_idx) == 3'd1) |-> !supply);

  // R9: upgrade elsewhere invalidates with no write-back
  a_r9_upgrade_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == 2'd2) |=> pick(st_flat, $past(snp_idx)) == 3'd0);

  // R4: owner write goes out as an upgrade
  a_r4_owner_write_upgr: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !snp_valid && cpu_op == 2'd1 && pick(st_flat, cpu_idx) == 3'd3)
      |-> bus_req && bus_op == 2'd2);

  // R11: stalled request has no visible effect
  a_r11_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> !bus_req && !wb);
endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
  .cpu_stall(cpu_stall), .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
  .bus_req(bus_req), .bus_op(bus_op), .supply(supply), .wb(wb), .st_flat(st_flat)
);

// File: tb/moesi_line_ctrl_test.sv
`timescale 1ns/1ps
module moesi_line_ctrl_test;
  localparam int LINES = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_peer_copy = 1'b0, snp_valid = 1'b0;
  logic [1:0] cpu_op = 2'd3, snp_op = 2'd3;
  logic [IW-1:0] cpu_idx = '0, snp_idx = '0, probe_idx = '0;
  logic cpu_stall, bus_req, inval, supply, wb;
  logic [1:0] bus_op;
  logic [2:0] probe_state;

  int checks = 0;
  int errors = 0;
  logic [2:0] model [LINES];

  always #4 clk = ~clk;

  moesi_line_ctrl #(.LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
    .cpu_peer_copy(cpu_peer_copy), .cpu_stall(cpu_stall), .snp_valid(snp_valid),
    .snp_op(snp_op), .snp_idx(snp_idx), .bus_req(bus_req), .bus_op(bus_op), .inval(inval),
    .supply(supply), .wb(wb), .probe_idx(probe_idx), .probe_state(probe_state)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic void cpu_model(input logic [2:0] s, input logic [1:0] op, input logic pc,
      output logic [2:0] n, output logic rq, output logic [1:0] ro, output logic iv, output logic w);
    n = s; rq = 0; ro = 0; iv = 0; w = 0;
    if (op == 2'd0 && s == 3'd0) begin rq = 1; n = pc ? 3'd1 : 3'd2; end
    if (op == 2'd1) begin
      n = 3'd4;
      if (s == 3'd0) begin rq = 1; ro = 2'd1; iv = 1; end
      if (s == 3'd1 || s == 3'd3) begin rq = 1; ro = 2'd2; iv = 1; end
    end
    if (op == 2'd2) begin n = 3'd0; w = (s == 3'd3 || s == 3'd4); end
  endfunction

  function automatic void snp_model(input logic [2:0] s, input logic [1:0] op,
      output logic [2:0] n, output logic sp);
    n = s; sp = 0;
    if (s != 3'd0) begin
      if (op == 2'd0) begin
        sp = (s != 3'd1);
        if (s == 3'd4) n = 3'd3;
        if (s == 3'd2) n = 3'd1;
      end
      if (op == 2'd1) begin sp = (s != 3'd1); n = 3'd0; end
      if (op == 2'd2) n = 3'd0;
    end
  endfunction

  task automatic settle(input int idx, input string req);
    int nb;
    @(negedge clk);
    cpu_valid = 0; snp_valid = 0;
    nb = (idx + 1) % LINES;
    probe_idx = IW'(idx);
    #1 check({req, " state"}, probe_state, model[idx]);
    probe_idx = IW'(nb);
    #1 check("R12 neighbour", probe_state, model[nb]);
  endtask

  task automatic do_cpu(input int idx, input logic [1:0] op, input logic pc, input string req);
    logic [2:0] n; logic rq, iv, w; logic [1:0] ro;
    cpu_model(model[idx], op, pc, n, rq, ro, iv, w);
    cpu_valid = 1; cpu_op = op; cpu_idx = IW'(idx); cpu_peer_copy = pc;
    #1;
    check({req, " bus_req"}, bus_req, rq);
    if (rq) check({req, " bus_op"}, bus_op, ro);
    check({req, " inval"}, inval, iv);
    check({req, " wb"}, wb, w);
    check({req, " supply"}, supply, 0);
    @(posedge clk);
    model[idx] = n;
    settle(idx, req);
  endtask

  task automatic do_snp(input int idx, input logic [1:0] op, input string req);
    logic [2:0] n; logic sp;
    snp_model(model[idx], op, n, sp);
    snp_valid = 1; snp_op = op; snp_idx = IW'(idx);
    #1;
    check({req, " supply"}, supply, sp);
    check({req, " wb"}, wb, 0);
    check({req, " bus_req"}, bus_req, 0);
    @(posedge clk);
    model[idx] = n;
    settle(idx, req);
  endtask

  task automatic reach(input int idx, input int s);
    do_cpu(idx, 2'd2, 0, "R6 setup");
    case (s)
      1: do_cpu(idx, 2'd0, 1, "R2 setup");
      2: do_cpu(idx, 2'd0, 0, "R2 setup");
      3: begin do_cpu(idx, 2'd1, 0, "R4 setup"); do_snp(idx, 2'd0, "R3 setup"); end
      4: do_cpu(idx, 2'd1, 0, "R4 setup");
      default: ;
    endcase
  endtask

  function automatic string tag_cpu(input int s, input int op);
    if (op == 0) return "R2";
    if (op == 1) return "R4";
    return "R6";
  endfunction

  function automatic string tag_snp(input int s, input int op);
    if (s == 0) return "R10";
    if (s == 1) return "R8";
    if (op == 2) return "R9";
    if (op == 1) return "R7";
    if (s == 4) return "R3";
    return "R5";
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    summary();
  end

  initial begin
    for (int i = 0; i < LINES; i++) model[i] = 3'd0;
    repeat (3) @(negedge clk);
    #1 check("R1 outputs", {bus_req, inval, supply, wb}, 0);
    for (int i = 0; i < LINES; i++) begin
      probe_idx = IW'(i);
      #1 check("R1 state", probe_state, 0);
    end
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < LINES; i++) begin
      probe_idx = IW'(i);
      #1 check("R1 state after release", probe_state, 0);
    end
    for (int s = 0; s < 5; s++) begin
      for (int op = 0; op < 3; op++) begin
        for (int pc = 0; pc < 2; pc++) begin
          reach((s + op) % LINES, s);
          do_cpu((s + op) % LINES, 2'(op), 1'(pc), tag_cpu(s, op));
        end
      end
      for (int op = 0; op < 3; op++) begin
        reach((s + op + 1) % LINES, s);
        do_snp((s + op + 1) % LINES, 2'(op), tag_snp(s, op));
      end
    end
    // R11: collision, snoop wins and processor request is dropped
    for (int s = 1; s < 5; s++) begin
      logic [2:0] n; logic sp;
      reach(1, s);
      reach(2, 0);
      snp_model(model[1], 2'd0, n, sp);
      cpu_valid = 1; cpu_op = 2'd1; cpu_idx = 2'd2; cpu_peer_copy = 0;
      snp_valid = 1; snp_op = 2'd0; snp_idx = 2'd1;
      #1;
      check("R11 stall", cpu_stall, 1);
      check("R11 bus_req", bus_req, 0);
      check("R11 supply", supply, sp);
      @(posedge clk);
      model[1] = n;
      settle(1, "R11 snoop");
      probe_idx = 2'd2;
      #1 check("R11 cpu line", probe_state, 0);
    end
    summary();
  end
endmodule